// File: doc/BRIEF.md
# SD Card Block-Read Receive Buffer

This block takes the data phase of a single-block read from an SD card and makes it available to a processor. Once software has issued the read command, it pulses an arm input. The block then watches the serial data line. On each sampled rising edge of the card clock it shifts in one bit. It skips idle all-ones bits until it finds the start token 0xFE. It then builds 512 bytes, most significant bit first, and writes them in order into an on-chip 512-byte buffer. The 16 CRC bits that follow are clocked through and dropped.

After the last CRC bit, a received flag is raised. No interrupt is produced: software polls the flag at the command/status offset of a 3-bit register window. It then pulls the block out one byte per read at the data offset. Every data read steps an internal read pointer, which wraps from byte 511 back to byte 0. Register reads are combinational from the address, so the value is valid in the same cycle as the read strobe.

Top module: `sd_rx_buffer`

## Requirements
- R1: After reset the received flag is 0, the status offset (0) reads 0x00 and the read pointer is at byte 0.
- R2: After arming, all-ones idle bits on the line store nothing and do not raise the flag; reception starts only after the last eight sampled bits equal 0xFE.
- R3: After the token, each group of eight sampled bits forms one byte, with the first bit sampled landing in bit 7.
- R4: The 512 bytes after the token are stored at buffer positions 0 to 511 in arrival order, and reading offset 5 returns them in that order.
- R5: Each read of offset 5 advances the read pointer by one, and after byte 511 the next read returns byte 0.
- R6: The 16 bits after the 512th byte are consumed without being stored, and the flag stays 0 until the last of them has been sampled.
- R7: The cycle after the last CRC bit is sampled, offset 0 reads 0x01 (flag in bit 0, bits 7..1 zero).
- R8: Any CPU read of the window, at any offset, clears the flag on the following clock; a completion in the same cycle wins over the clear.
- R9: Reads at offsets other than 0 and 5 return 0x00 and leave the read pointer unchanged.
- R10: The data line is sampled only in cycles where the bit strobe is high; its value in other cycles has no effect.
- R11: Arming, including in the middle of a block, resets the read and write positions to byte 0 and restarts the token search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_arm | input | 1 | One-cycle pulse: expect a new data block |
| sd_bit_valid | input | 1 | Strobe marking the card-clock rising edge at which sd_bit is sampled |
| sd_bit | input | 1 | Serial data line from the card |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_addr | input | 3 | Register window offset |
| cpu_rdata | output | 8 | Combinational read data for cpu_addr |

## Verification
The assertions assume that sd_bit_valid is at most a single-cycle pulse per card-clock rising edge and that rx_arm and cpu_rd are one-cycle pulses. They also assume that reads at the data offset never occur in the same cycle as an arm. The stimulus respects these assumptions. Bits are driven at the falling system edge with the strobe high for one cycle and low for the next. Arm and read pulses are issued only between bit strobes. Line values that the block must ignore are driven only while the strobe is low.

// File: rtl/sdrx_pkg.sv
package sdrx_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_TOKEN = 2'd1,
        RX_DATA  = 2'd2,
        RX_CRC   = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic              we;
        logic [BYTE_W-1:0] data;
    } byte_wr_t;

    function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] s, input logic b);
        return {s[BYTE_W-2:0], b};
    endfunction

endpackage

// File: rtl/sdrx_deser.sv
module sdrx_deser
    import sdrx_pkg::*;
#(
    parameter int BLOCK_BYTES = 512,
    parameter int CRC_BITS    = 16,
    parameter logic [7:0] START_TOKEN = 8'hFE,
    localparam int PTR_W = $clog2(BLOCK_BYTES),
    localparam int CRC_CW = $clog2(CRC_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             bit_valid,
    input  logic             bit_in,
    output byte_wr_t         wr,
    output logic [PTR_W-1:0] wr_addr,
    output logic             blk_done
);

    localparam logic [PTR_W-1:0]  LAST_BYTE = PTR_W'(BLOCK_BYTES - 1);
    localparam logic [CRC_CW-1:0] CRC_LAST  = CRC_CW'(CRC_BITS - 1);

    rx_state_e          state;
    logic [BYTE_W-1:0]  shreg;
    logic [BYTE_W-1:0]  shnext;
    logic [2:0]         bitcnt;
    logic [PTR_W-1:0]   bytecnt;
    logic [CRC_CW-1:0]  crccnt;

    assign shnext = shift_in(shreg, bit_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            shreg   <= '1;
            bitcnt  <= '0;
            bytecnt <= '0;
            crccnt  <= '0;
        end else if (arm) begin
            state   <= RX_TOKEN;
            shreg   <= '1;
            bytecnt <= '0;
        end else if (bit_valid) begin
            case (state)
                RX_TOKEN: begin
                    if (shnext == START_TOKEN) begin
                        state  <= RX_DATA;
                        bitcnt <= 3'd7;
                        shreg  <= '1;
                    end else begin
                        shreg <= shnext;
                    end
                end
                RX_DATA: begin
                    shreg <= shnext;
                    if (bitcnt == 3'd0) begin
                        bitcnt  <= 3'd7;
                        bytecnt <= bytecnt + 1'b1;
                        if (bytecnt == LAST_BYTE) begin
                            state  <= RX_CRC;
                            crccnt <= CRC_LAST;
                        end
                    end else begin
                        bitcnt <= bitcnt - 1'b1;
                    end
                end
                RX_CRC: begin
                    if (crccnt == '0) state <= RX_IDLE;
                    else              crccnt <= crccnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        wr.we    = bit_valid && !arm && (state == RX_DATA) && (bitcnt == 3'd0);
        wr.data  = shnext;
        wr_addr  = bytecnt;
        blk_done = bit_valid && !arm && (state == RX_CRC) && (crccnt == '0);
    end

endmodule

// File: rtl/sdrx_buffer.sv
module sdrx_buffer
    import sdrx_pkg::*;
#(
    parameter int BLOCK_BYTES = 512,
    localparam int PTR_W = $clog2(BLOCK_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  byte_wr_t          wr,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic              rd_adv,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic [BYTE_W-1:0] rd_byte
);

    logic [BYTE_W-1:0] mem [BLOCK_BYTES];

    always_ff @(posedge clk) begin
        if (wr.we) mem[wr_addr] <= wr.data;
    end

    always_ff @(posedge clk) begin
        if (rst || arm)  rd_ptr <= '0;
        else if (rd_adv) rd_ptr <= rd_ptr + 1'b1;
    end

    assign rd_byte = mem[rd_ptr];

endmodule

// File: rtl/sdrx_regs.sv
module sdrx_regs
    import sdrx_pkg::*;
#(
    parameter int ADDR_W   = 3,
    parameter int DATA_OFS = 5,
    parameter int STAT_OFS = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BYTE_W-1:0] rd_byte,
    input  logic              blk_done,
    output logic              rd_adv,
    output logic              rx_flag,
    output logic [BYTE_W-1:0] cpu_rdata
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    assign rd_adv = cpu_rd && (cpu_addr == A_DATA);

    always_ff @(posedge clk) begin
        if (rst)           rx_flag <= 1'b0;
        else if (blk_done) rx_flag <= 1'b1;
        else if (cpu_rd)   rx_flag <= 1'b0;
    end

    always_comb begin
        if (cpu_addr == A_DATA)      cpu_rdata = rd_byte;
        else if (cpu_addr == A_STAT) cpu_rdata = {{(BYTE_W-1){1'b0}}, rx_flag};
        else                         cpu_rdata = '0;
    end

endmodule

// File: rtl/sd_rx_buffer.sv
module sd_rx_buffer
    import sdrx_pkg::*;
#(
    parameter int BLOCK_BYTES = 512,
    parameter int CRC_BITS    = 16,
    parameter int ADDR_W      = 3,
    parameter int DATA_OFS    = 5,
    parameter int STAT_OFS    = 0,
    localparam int PTR_W = $clog2(BLOCK_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_arm,
    input  logic              sd_bit_valid,
    input  logic              sd_bit,
    input  logic              cpu_rd,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [7:0]        cpu_rdata
);

    byte_wr_t          byte_wr;
    logic [PTR_W-1:0]  wr_addr;
    logic              blk_done;
    logic              rd_adv;
    logic [PTR_W-1:0]  rd_ptr;
    logic [BYTE_W-1:0] rd_byte;
    logic              rx_flag;

    sdrx_deser #(
        .BLOCK_BYTES(BLOCK_BYTES),
        .CRC_BITS   (CRC_BITS),
        .START_TOKEN(8'hFE)
    ) u_deser (
        .clk      (clk),
        .rst      (rst),
        .arm      (rx_arm),
        .bit_valid(sd_bit_valid),
        .bit_in   (sd_bit),
        .wr       (byte_wr),
        .wr_addr  (wr_addr),
        .blk_done (blk_done)
    );

    sdrx_buffer #(
        .BLOCK_BYTES(BLOCK_BYTES)
    ) u_buf (
        .clk    (clk),
        .rst    (rst),
        .arm    (rx_arm),
        .wr     (byte_wr),
        .wr_addr(wr_addr),
        .rd_adv (rd_adv),
        .rd_ptr (rd_ptr),
        .rd_byte(rd_byte)
    );

    sdrx_regs #(
        .ADDR_W  (ADDR_W),
        .DATA_OFS(DATA_OFS),
        .STAT_OFS(STAT_OFS)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cpu_rd   (cpu_rd),
        .cpu_addr (cpu_addr),
        .rd_byte  (rd_byte),
        .blk_done (blk_done),
        .rd_adv   (rd_adv),
        .rx_flag  (rx_flag),
        .cpu_rdata(cpu_rdata)
    );

endmodule

// File: rtl/sd_rx_buffer_chk.sv
module sd_rx_buffer_chk #(
    parameter int ADDR_W   = 3,
    parameter int PTR_W    = 9,
    parameter int DATA_OFS = 5,
    parameter int STAT_OFS = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              arm,
    input logic              bit_valid,
    input logic              cpu_rd,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [7:0]        cpu_rdata,
    input logic              byte_we,
    input logic              blk_done,
    input logic              rx_flag,
    input logic [PTR_W-1:0]  rd_ptr
);

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFS);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);

    assert_we_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        byte_we |-> bit_valid);

    assert_done_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        blk_done |-> bit_valid);

    assert_flag_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_flag) |-> $past(blk_done));

    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && rx_flag && !blk_done) |=> !rx_flag);

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && cpu_addr == A_DATA && !arm) |=> rd_ptr == $past(rd_ptr) + PTR_W'(1));

    assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!arm && !(cpu_rd && cpu_addr == A_DATA)) |=> $stable(rd_ptr));

    assert_other_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr != A_DATA && cpu_addr != A_STAT) |-> cpu_rdata == 8'h00);

    assert_status_bits_R7: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr == A_STAT) |-> cpu_rdata[7:1] == 7'd0);

    assert_arm_ptr_R11: assert property (@(posedge clk) disable iff (rst)
        arm |=> rd_ptr == '0);

endmodule

bind sd_rx_buffer sd_rx_buffer_chk #(
    .ADDR_W  (ADDR_W),
    .PTR_W   (PTR_W),
    .DATA_OFS(DATA_OFS),
    .STAT_OFS(STAT_OFS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .arm      (rx_arm),
    .bit_valid(sd_bit_valid),
    .cpu_rd   (cpu_rd),
    .cpu_addr (cpu_addr),
    .cpu_rdata(cpu_rdata),
    .byte_we  (byte_wr.we),
    .blk_done (blk_done),
    .rx_flag  (rx_flag),
    .rd_ptr   (rd_ptr)
);

// File: tb/sd_rx_buffer_tb_top.sv
module sd_rx_buffer_tb_top;

    localparam int NBYTES = 512;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_arm = 1'b0;
    logic       sd_bit_valid = 1'b0;
    logic       sd_bit = 1'b1;
    logic       cpu_rd = 1'b0;
    logic [2:0] cpu_addr = 3'd0;
    logic [7:0] cpu_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0] exp_q [$];
    logic [7:0] first_byte;
    logic [7:0] v;

    always #10 clk = ~clk;

    sd_rx_buffer dut_i (
        .clk         (clk),
        .rst         (rst),
        .rx_arm      (rx_arm),
        .sd_bit_valid(sd_bit_valid),
        .sd_bit      (sd_bit),
        .cpu_rd      (cpu_rd),
        .cpu_addr    (cpu_addr),
        .cpu_rdata   (cpu_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic arm_pulse();
        @(negedge clk); rx_arm = 1'b1;
        @(negedge clk); rx_arm = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); sd_bit = b; sd_bit_valid = 1'b1;
        @(negedge clk); sd_bit_valid = 1'b0;
    endtask

    // MSB first (R3)
    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    function automatic logic [7:0] pattern(input int seed, input int i);
        return 8'((i * 7 + seed) & 8'hFF);
    endfunction

    // Driver: header plus data bytes, each pushed to the scoreboard
    task automatic drive_data(input int seed, input int idle_n, input bit push);
        for (int i = 0; i < idle_n; i++) send_byte(8'hFF);
        send_byte(8'hFE);
        for (int i = 0; i < NBYTES; i++) begin
            send_byte(pattern(seed, i));
            if (push) exp_q.push_back(pattern(seed, i));
        end
    endtask

    task automatic cpu_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); cpu_addr = a; cpu_rd = 1'b1;
        #5 d = cpu_rdata;
        @(negedge clk); cpu_rd = 1'b0;
    endtask

    // Monitor: pops the expected item and compares with each data read
    task automatic read_block(input int n);
        logic [7:0] d, e;
        for (int i = 0; i < n; i++) begin
            cpu_read(3'd5, d);
            e = exp_q.pop_front();
            check(d === e, "R4 data readback (R3 bit order)", d, e);
            if (i % 128 == 64) begin
                cpu_read(3'd3, d);
                check(d === 8'h00, "R9 unused offset reads zero", d, 8'h00);
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 200000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=%0d cycles expected<200000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        cpu_read(3'd0, v);
        check(v === 8'h00, "R1 status after reset", v, 8'h00);
        cpu_read(3'd7, v);
        check(v === 8'h00, "R9 offset 7 reads zero", v, 8'h00);

        // Block A with idle bits and ignored line activity
        arm_pulse();
        for (int i = 0; i < 3; i++) send_byte(8'hFF);
        cpu_read(3'd0, v);
        check(v === 8'h00, "R2 idle bits raise no flag", v, 8'h00);
        // R10: line low without strobe must be ignored
        @(negedge clk); sd_bit = 1'b0;
        repeat (20) @(negedge clk);
        sd_bit = 1'b1;
        drive_data(3, 2, 1'b1);
        first_byte = pattern(3, 0);
        for (int i = 0; i < 15; i++) send_bit(i[0]);
        cpu_read(3'd0, v);
        check(v === 8'h00, "R6 flag low before last CRC bit", v, 8'h00);
        send_bit(1'b0);
        cpu_read(3'd0, v);
        check(v === 8'h01, "R7 flag after block", v, 8'h01);
        cpu_read(3'd0, v);
        check(v === 8'h00, "R8 flag cleared by read", v, 8'h00);

        read_block(NBYTES);
        cpu_read(3'd5, v);
        check(v === first_byte, "R5 wrap to byte 0 (R6 CRC not stored)", v, first_byte);

        // Block B: arm resets pointer (R11); clear via other offset (R8)
        arm_pulse();
        drive_data(100, 0, 1'b1);
        send_byte(8'h12); send_byte(8'h34);
        cpu_read(3'd2, v);
        check(v === 8'h00, "R9 offset 2 reads zero", v, 8'h00);
        cpu_read(3'd0, v);
        check(v === 8'h00, "R8 flag cleared by read at other offset", v, 8'h00);
        read_block(NBYTES);

        // Block C: re-arm in the middle of a block (R11)
        arm_pulse();
        send_byte(8'hFF); send_byte(8'hFE);
        for (int i = 0; i < 40; i++) send_byte(8'hA5);
        arm_pulse();
        drive_data(201, 1, 1'b1);
        send_byte(8'hFE); send_byte(8'hFF);
        cpu_read(3'd0, v);
        check(v === 8'h01, "R11 flag after restarted block", v, 8'h01);
        first_byte = pattern(201, 0);
        read_block(NBYTES);
        cpu_read(3'd5, v);
        check(v === first_byte, "R5 wrap after restarted block", v, first_byte);
        check(exp_q.size() == 0, "R4 scoreboard drained", 8'(exp_q.size()), 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule